// File: doc/BRIEF.md
# Accumulator Processor with Explicit Fetch, Decode and Execute Phases

This block is a small accumulator machine. Its control unit walks through visible phases, and every step moves one value between named registers: a program counter, a memory address register, a memory data register, an instruction register and an accumulator. A single-port word memory sits inside the block. Its address bus is driven only by the address register, and its read data lands only in the data register.

A test harness or boot agent holds the core in reset and writes a program and its data through the loader port. It then releases reset. The core starts at address 0 and runs until it meets a stop instruction. From then on it shows `halted` and its register contents stay frozen.

An instruction is 16 bits wide. Bits [15:12] hold the opcode and bits [11:0] hold an operand address. Three opcodes are defined:

- 0x1 loads the accumulator.
- 0x2 adds a memory word to the accumulator.
- 0xF stops the core.

Every other opcode also stops the core.

Top module: `acc_fde_core`

## Requirements
- R1: A cycle with `rst` high clears the program counter, address, data, instruction and accumulator registers to zero, sets `phase` to 0 and drives `halted` low, so that execution begins at address 0.
- R2: A loader write with `ld_we` high stores `ld_data` at `ld_addr`, taken modulo MEM_DEPTH. It takes effect only in a cycle with `rst` high. With `rst` low the write is ignored and memory is left unchanged.
- R3: The fetch phases each take one cycle. Phase 0 copies the program counter into the address register. Phase 1 reads the addressed word into the data register. Phase 2 copies the data register into the instruction register.
- R4: Phase 3 is decode. It increments the program counter by exactly one, and no other phase changes the program counter. In decode, bits [15:12] of the instruction register are taken as the opcode and bits [11:0] as the operand address.
- R5: Opcode 0x1 (load) runs three execute phases, then returns to phase 0. Phase 4 puts the operand address into the address register. Phase 5 reads that word into the data register. Phase 6 copies the data register into the accumulator. A load or add instruction therefore takes 7 cycles.
- R6: Opcode 0x2 (add) uses the same phases 4 and 5 as load. In phase 6 it adds the data register to the accumulator, modulo 2^16.
- R7: Opcode 0xF, and any opcode other than 0x1 or 0x2, moves from decode to phase 7 and raises `halted`. A stop instruction takes 4 cycles and leaves the address register unchanged. After it, no further fetch happens, `halted` stays high, and only reset clears it.
- R8: Every register keeps its value until its own phase writes it. In particular, the accumulator changes only in phase 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loader window |
| ld_we | input | 1 | Loader write enable (effective only in reset) |
| ld_addr | input | 12 | Loader word address |
| ld_data | input | 16 | Loader write data |
| halted | output | 1 | Stop instruction has executed |
| phase | output | 3 | Current control phase, 0 to 7 |
| pc_q | output | 12 | Program counter |
| mar_q | output | 12 | Memory address register |
| mdr_q | output | 16 | Memory data register |
| ir_q | output | 16 | Instruction register |
| acc_q | output | 16 | Accumulator |

## Verification
The properties assume that the loader is active only while `rst` is high. They also assume that a run is always started by a reset, so the phase register begins at 0. The bench writes memory only inside reset windows, except for one deliberate write outside reset, which probes R2. It never drops reset in the middle of loading. Each program ends in a stop word, or in a word with an undefined opcode, placed so that the program counter never wraps while the core is running.

// File: rtl/acc_fde_core.sv
module acc_fde_core #(
  parameter int DATA_W    = 16,
  parameter int OP_W      = 4,
  parameter int MEM_DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_we,
  input  logic [DATA_W-OP_W-1:0]   ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  output logic                     halted,
  output logic [2:0]               phase,
  output logic [DATA_W-OP_W-1:0]   pc_q,
  output logic [DATA_W-OP_W-1:0]   mar_q,
  output logic [DATA_W-1:0]        mdr_q,
  output logic [DATA_W-1:0]        ir_q,
  output logic [DATA_W-1:0]        acc_q
);
  localparam int ADDR_W = DATA_W - OP_W;
  localparam int IDX_W  = $clog2(MEM_DEPTH);
  localparam logic [OP_W-1:0] OP_LOAD = OP_W'(1);
  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(2);

  typedef enum logic [2:0] {
    S_FMAR = 3'd0, S_FRD = 3'd1, S_FIR = 3'd2, S_DEC = 3'd3,
    S_EMAR = 3'd4, S_ERD = 3'd5, S_EACC = 3'd6, S_STOP = 3'd7
  } state_t;

  state_t st;
  logic [DATA_W-1:0] mem [MEM_DEPTH];

  wire [OP_W-1:0]   opcode  = ir_q[DATA_W-1 -: OP_W];
  wire [ADDR_W-1:0] operand = ir_q[ADDR_W-1:0];
  wire [IDX_W-1:0]  rd_idx  = mar_q[IDX_W-1:0];
  wire [IDX_W-1:0]  wr_idx  = ld_addr[IDX_W-1:0];
  wire              known   = (opcode == OP_LOAD) || (opcode == OP_ADD);
  wire              unused_ld_hi = ^ld_addr[ADDR_W-1:IDX_W];

  assign phase  = st;
  assign halted = (st == S_STOP);

  always_ff @(posedge clk)
    if (rst && ld_we) mem[wr_idx] <= ld_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_FMAR;
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      case (st)
        S_FMAR: begin mar_q <= pc_q;        st <= S_FRD;  end
        S_FRD:  begin mdr_q <= mem[rd_idx]; st <= S_FIR;  end
        S_FIR:  begin ir_q  <= mdr_q;       st <= S_DEC;  end
        S_DEC:  begin
          pc_q <= pc_q + 1'b1;
          st   <= known ? S_EMAR : S_STOP;
        end
        S_EMAR: begin mar_q <= operand;     st <= S_ERD;  end
        S_ERD:  begin mdr_q <= mem[rd_idx]; st <= S_EACC; end
        S_EACC: begin
          acc_q <= (opcode == OP_ADD) ? acc_q + mdr_q : mdr_q;
          st    <= S_FMAR;
        end
        default: st <= S_STOP;
      endcase
    end
  end
endmodule

module acc_fde_checker #(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   halted,
  input logic [2:0]             phase,
  input logic [DATA_W-OP_W-1:0] pc_q,
  input logic [DATA_W-OP_W-1:0] mar_q,
  input logic [DATA_W-1:0]      acc_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rst || (phase == 3'd0 && pc_q == '0 && acc_q == '0 && !halted)));

  assert_fetch_order_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0) |=> (phase == 3'd1));

  assert_ir_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1) |=> (phase == 3'd2));

  assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd3) |=> $stable(pc_q));

  assert_exec_return_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd6) |=> (phase == 3'd0));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(mar_q) && $stable(pc_q)));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd6) |=> $stable(acc_q));
endmodule

bind acc_fde_core acc_fde_checker #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .phase(phase),
  .pc_q(pc_q), .mar_q(mar_q), .acc_q(acc_q)
);

// File: tb/acc_fde_core_bench.sv
`timescale 1ns/1ps
module acc_fde_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        halted;
  logic [2:0]  phase;
  logic [11:0] pc_q, mar_q;
  logic [15:0] mdr_q, ir_q, acc_q;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  acc_fde_core u_acc_fde_core (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .phase(phase), .pc_q(pc_q), .mar_q(mar_q),
    .mdr_q(mdr_q), .ir_q(ir_q), .acc_q(acc_q)
  );

  // {instr0, instr1, word@40, word@41, expected acc, expected pc[15:8] / cycles[7:0]}
  localparam logic [95:0] VEC [7] = '{
    {16'h1028, 16'h2029, 16'h0006, 16'h0007, 16'h000D, 8'd3, 8'd18},
    {16'h1029, 16'h1028, 16'h1234, 16'h5555, 16'h1234, 8'd3, 8'd18},
    {16'h2028, 16'h2028, 16'h8000, 16'h0000, 16'h0000, 8'd3, 8'd18},
    {16'h1028, 16'h2029, 16'hFFFF, 16'h0002, 16'h0001, 8'd3, 8'd18},
    {16'hF000, 16'h1028, 16'h0011, 16'h0022, 16'h0000, 8'd1, 8'd4},
    {16'h7028, 16'h1028, 16'h0011, 16'h0022, 16'h0000, 8'd1, 8'd4},
    {16'h1028, 16'h0029, 16'h00AB, 16'h0001, 16'h00AB, 8'd2, 8'd11}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic load_prog(input logic [95:0] v);
    @(negedge clk);
    rst = 1'b1;
    poke(12'd0, v[95:80]);
    poke(12'd1, v[79:64]);
    poke(12'd2, 16'hF000);
    poke(12'd40, v[63:48]);
    poke(12'd41, v[47:32]);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (2) @(negedge clk);
    // R1 after cold reset
    check("R1 pc", 16'(pc_q), 16'h0);
    check("R1 acc", acc_q, 16'h0);
    check("R1 phase", 16'(phase), 16'h0);
    check("R1 halted", 16'(halted), 16'h0);

    for (int i = 0; i < 7; i++) begin
      logic [95:0] v;
      v = VEC[i];
      load_prog(v);
      run(cyc);
      check($sformatf("R5 R6 R7 vec%0d acc", i), acc_q, v[31:16]);
      check($sformatf("R4 vec%0d pc", i), 16'(pc_q), 16'(v[15:8]));
      check($sformatf("R5 R7 vec%0d cycles", i), 16'(cyc), 16'(v[7:0]));
      check($sformatf("R7 vec%0d halted", i), 16'(halted), 16'h1);
      check($sformatf("R7 vec%0d mar", i), 16'(mar_q), 16'(v[15:8] - 8'd1));
      check($sformatf("R3 vec%0d ir", i), ir_q, (v[15:8] == 8'd3) ? 16'hF000 :
            (v[15:8] == 8'd1) ? v[95:80] : v[79:64]);
    end

    // R7: no further activity while halted
    repeat (20) @(negedge clk);
    check("R7 halted stays", 16'(halted), 16'h1);
    check("R7 pc frozen", 16'(pc_q), 16'h2);
    check("R8 acc frozen", acc_q, 16'h00AB);
    check("R7 phase", 16'(phase), 16'h7);

    // R1 from halted state
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 clears halted", 16'(halted), 16'h0);
    check("R1 clears acc", acc_q, 16'h0);
    check("R1 clears mar", 16'(mar_q), 16'h0);
    check("R1 clears mdr", mdr_q, 16'h0);
    check("R1 clears ir", ir_q, 16'h0);
    check("R1 clears pc", 16'(pc_q), 16'h0);

    // R3 R4 R5 step by step on the first program
    load_prog(VEC[0]);
    @(negedge clk); rst = 1'b0;
    check("R3 start phase", 16'(phase), 16'h0);
    @(negedge clk);
    check("R3 ph1", 16'(phase), 16'h1);
    check("R3 mar<-pc", 16'(mar_q), 16'h0);
    @(negedge clk);
    check("R3 ph2", 16'(phase), 16'h2);
    check("R3 mdr<-mem", mdr_q, 16'h1028);
    check("R4 pc unchanged at fetch", 16'(pc_q), 16'h0);
    @(negedge clk);
    check("R3 ph3", 16'(phase), 16'h3);
    check("R3 ir<-mdr", ir_q, 16'h1028);
    check("R4 pc before decode", 16'(pc_q), 16'h0);
    @(negedge clk);
    check("R4 ph4", 16'(phase), 16'h4);
    check("R4 pc after decode", 16'(pc_q), 16'h1);
    @(negedge clk);
    check("R5 ph5", 16'(phase), 16'h5);
    check("R5 mar<-operand", 16'(mar_q), 16'h028);
    check("R8 acc held", acc_q, 16'h0);
    @(negedge clk);
    check("R5 ph6", 16'(phase), 16'h6);
    check("R5 mdr<-data", mdr_q, 16'h0006);
    check("R8 acc still held", acc_q, 16'h0);
    @(negedge clk);
    check("R5 back to ph0", 16'(phase), 16'h0);
    check("R5 acc<-mdr", acc_q, 16'h0006);
    check("R8 ir held", ir_q, 16'h1028);
    while (!halted) @(negedge clk);
    check("R6 add result", acc_q, 16'h000D);

    // R2: loader write outside reset is ignored
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 12'd41; ld_data = 16'h0100;
    @(negedge clk);
    ld_we = 1'b0;
    check("R2 no effect while halted", acc_q, 16'h000D);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    run(cyc);
    check("R2 memory unchanged", acc_q, 16'h000D);
    check("R2 cycles", 16'(cyc), 16'd18);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule